// File: doc/BRIEF.md
# Backlight Dimming PWM with Committed Settings

This block drives a single pulse-width-modulated line for display backlight dimming. Software sets three values through a small word-addressed register port: a prescaler divide value, a period length and a high width. It also sets an enable bit. The prescaler slows the input clock. A period counter then advances once per prescaled tick, and the output is high while that counter is below the high width.

The divide, period and width values are only staged when they are written. A write of 1 and then 0 to a commit flag copies them into a pending set. That pending set moves into the running counters at the end of the current output period, so a period in progress always completes with its old settings. When the block is disabled, the move happens on the next clock instead. Reads return the staged values, not the running ones.

Top module: `bl_pwm_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the block is disabled and `pwm_out` is low.
- R2: Word address 0 holds the enable in bit 0. Word 2 holds the commit flag in bit 0. Word 4 holds the divide value in bits 25:16. Word 5 holds the period in bits 11:0 and the high width in bits 28:16. Undefined bits and unmapped addresses read zero, and `reg_rdata` is zero while `reg_rd` is low.
- R3: Writes to the divide, period or width fields do not change `pwm_out` until a commit sequence follows.
- R4: While enabled, one output period lasts (divide+1)*(period+1) clock cycles.
- R5: In each period the output is high for the first (divide+1)*width cycles and low for the rest.
- R6: A committed width of 0 holds the output low while enabled.
- R7: A committed width of period+1 or more holds the output high for the whole period.
- R8: While the enable bit is 0, the output is low. In the cycle after enable is written to 1, a new period starts from its first cycle.
- R9: A commit made while enabled takes effect only at the end of the period in progress. The commit is the write of 1 and then 0 to the commit flag, and the values used are those staged at the write of 0.
- R10: A commit made while disabled reaches the running settings one cycle after the write of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the PWM time base |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| pwm_out | output | 1 | Dimming waveform |

## Verification
The assertions assume that the register port changes only between clock edges and that reset is held low for at least one edge before any access. They also assume that a commit is only recognised by a write of 0 to a flag that currently reads 1. The stimulus drives every register access half a cycle away from the active edge and always writes the flag as a 1 followed by a 0. Settings are changed both mid-period and while disabled, so the pending-transfer paths are exercised under those same assumptions.

// File: rtl/bl_pwm_pkg.sv
// Shared constants for the backlight PWM: word addresses of the register
// port and the bit positions of the packed fields. Assumes 32-bit data.
package bl_pwm_pkg;
    localparam int DATA_W     = 32;
    localparam int ADR_ENABLE = 0;
    localparam int ADR_COMMIT = 2;
    localparam int ADR_CTRL0  = 4;
    localparam int ADR_CTRL1  = 5;
    localparam int DIV_LSB    = 16;
    localparam int PER_LSB    = 0;
    localparam int WID_LSB    = 16;
endpackage

// File: rtl/bl_pwm_regs.sv
// Register file of the backlight PWM. It holds the enable, the commit flag and
// the staged divide/period/width fields, and it decodes a commit as a write
// of 0 to a flag that reads 1. It assumes one access per cycle and
// full-word writes.
module bl_pwm_regs
    import bl_pwm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 10,
    parameter int PER_W  = 12,
    parameter int WID_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic              arm,
    output logic [DIV_W-1:0]  stg_div,
    output logic [PER_W-1:0]  stg_per,
    output logic [WID_W-1:0]  stg_wid
);
    logic cm_q;

    // Capture register writes; everything clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            cm_q    <= 1'b0;
            stg_div <= '0;
            stg_per <= '0;
            stg_wid <= '0;
        end else if (wr) begin
            if (addr == ADDR_W'(ADR_ENABLE)) en <= wdata[0];
            if (addr == ADDR_W'(ADR_COMMIT)) cm_q <= wdata[0];
            if (addr == ADDR_W'(ADR_CTRL0))  stg_div <= wdata[DIV_LSB +: DIV_W];
            if (addr == ADDR_W'(ADR_CTRL1)) begin
                stg_per <= wdata[PER_LSB +: PER_W];
                stg_wid <= wdata[WID_LSB +: WID_W];
            end
        end
    end

    // A commit completes when a set flag is written back to zero.
    always_comb arm = wr && (addr == ADDR_W'(ADR_COMMIT)) && cm_q && !wdata[0];

    // Read mux returning staged values, zero elsewhere and when idle.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADDR_W'(ADR_ENABLE)) rdata[0] = en;
            if (addr == ADDR_W'(ADR_COMMIT)) rdata[0] = cm_q;
            if (addr == ADDR_W'(ADR_CTRL0))  rdata[DIV_LSB +: DIV_W] = stg_div;
            if (addr == ADDR_W'(ADR_CTRL1)) begin
                rdata[PER_LSB +: PER_W] = stg_per;
                rdata[WID_LSB +: WID_W] = stg_wid;
            end
        end
    end
endmodule

// File: rtl/bl_pwm_commit.sv
// Commit path of the backlight PWM. A commit snapshots the staged fields into
// a pending set. The pending set moves into the running set at a period
// boundary, or on the next clock when the block is disabled. It assumes
// that the boundary input lasts for one cycle only.
module bl_pwm_commit #(
    parameter int DIV_W = 10,
    parameter int PER_W = 12,
    parameter int WID_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             en,
    input  logic             boundary,
    input  logic [DIV_W-1:0] stg_div,
    input  logic [PER_W-1:0] stg_per,
    input  logic [WID_W-1:0] stg_wid,
    output logic             pend,
    output logic [DIV_W-1:0] live_div,
    output logic [PER_W-1:0] live_per,
    output logic [WID_W-1:0] live_wid
);
    logic [DIV_W-1:0] snp_div;
    logic [PER_W-1:0] snp_per;
    logic [WID_W-1:0] snp_wid;
    logic             xfer;

    // Transfer when pending and the running period may be replaced.
    always_comb xfer = pend && (!en || boundary);

    // Snapshot on commit, then move into the running set on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            snp_div  <= '0;
            snp_per  <= '0;
            snp_wid  <= '0;
            live_div <= '0;
            live_per <= '0;
            live_wid <= '0;
        end else begin
            if (xfer) begin
                live_div <= snp_div;
                live_per <= snp_per;
                live_wid <= snp_wid;
                pend     <= 1'b0;
            end
            if (arm) begin
                snp_div <= stg_div;
                snp_per <= stg_per;
                snp_wid <= stg_wid;
                pend    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bl_pwm_core.sv
// Waveform engine of the backlight PWM. It has a prescaler, a period counter
// and a width compare. It assumes that the running settings change only at a
// boundary or while disabled, which keeps both counters within range.
module bl_pwm_core #(
    parameter int DIV_W = 10,
    parameter int PER_W = 12,
    parameter int WID_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] live_div,
    input  logic [PER_W-1:0] live_per,
    input  logic [WID_W-1:0] live_wid,
    output logic             boundary,
    output logic             pwm_out
);
    localparam int CMP_W = (WID_W > PER_W) ? WID_W : PER_W;

    logic [DIV_W-1:0] pre_q;
    logic [PER_W-1:0] cnt_q;
    logic             tick;

    // Last prescaler step and last period step.
    always_comb begin
        tick     = (pre_q == live_div);
        boundary = en && tick && (cnt_q == live_per);
    end

    // Advance prescaler and period counter; hold at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            cnt_q <= (cnt_q == live_per) ? '0 : cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Output high while the period count is below the width.
    always_comb pwm_out = en && (CMP_W'(cnt_q) < CMP_W'(live_wid));
endmodule

// File: rtl/bl_pwm_top.sv
// Top of the backlight PWM. It connects the register file, the commit path
// and the waveform engine. It assumes a register port that is synchronous
// to clk.
module bl_pwm_top #(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 10,
    parameter int PER_W  = 12,
    parameter int WID_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pwm_out
);
    logic             en_q;
    logic             arm;
    logic             pend;
    logic             boundary;
    logic [DIV_W-1:0] stg_div, live_div;
    logic [PER_W-1:0] stg_per, live_per;
    logic [WID_W-1:0] stg_wid, live_wid;

    bl_pwm_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .en(en_q), .arm(arm),
        .stg_div(stg_div), .stg_per(stg_per), .stg_wid(stg_wid)
    );

    bl_pwm_commit #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .arm(arm), .en(en_q), .boundary(boundary),
        .stg_div(stg_div), .stg_per(stg_per), .stg_wid(stg_wid), .pend(pend),
        .live_div(live_div), .live_per(live_per), .live_wid(live_wid)
    );

    bl_pwm_core #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en_q), .live_div(live_div),
        .live_per(live_per), .live_wid(live_wid), .boundary(boundary),
        .pwm_out(pwm_out)
    );
endmodule

// File: rtl/bl_pwm_chk.sv
// Assertion checker for the backlight PWM, bound to the top. It observes the
// enable, the commit handshake, the running settings and the output.
module bl_pwm_chk #(
    parameter int DIV_W = 10,
    parameter int PER_W = 12,
    parameter int WID_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             arm,
    input logic             pend,
    input logic [DIV_W-1:0] live_div,
    input logic [PER_W-1:0] live_per,
    input logic [WID_W-1:0] live_wid,
    input logic             pwm_out
);
    // R8
    out_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out |-> en);

    // R6
    zero_width_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_wid == '0) |-> !pwm_out);

    // R7
    full_width_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ({1'b0, live_wid} > {1'b0, live_per})) |-> pwm_out);

    // R3
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable({live_div, live_per, live_wid}));

    // R10
    idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !en && !arm) |=> !pend);
endmodule

bind bl_pwm_top bl_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .arm(arm), .pend(pend),
    .live_div(live_div), .live_per(live_per), .live_wid(live_wid),
    .pwm_out(pwm_out)
);

// File: tb/bl_pwm_top_tb.sv
module bl_pwm_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_en = 0, m_cm = 0;
    int s_div = 0, s_per = 0, s_wid = 0;
    int n_div = 0, n_per = 0, n_wid = 0;
    int l_div = 0, l_per = 0, l_wid = 0;
    int m_pend = 0, pos = 0;

    always #2 clk = ~clk;

    bl_pwm_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out)
    );

    function automatic int exp_out();
        int hw;
        hw = (l_wid < l_per + 1) ? l_wid : l_per + 1;
        return (m_en != 0 && pos < (l_div + 1) * hw) ? 1 : 0;
    endfunction

    // model: position within the period in input cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_cm = 0; s_div = 0; s_per = 0; s_wid = 0;
            n_div = 0; n_per = 0; n_wid = 0; l_div = 0; l_per = 0; l_wid = 0;
            m_pend = 0; pos = 0;
        end else begin
            int plen;
            bit last, arm, xfer;
            plen = (l_div + 1) * (l_per + 1);
            last = (m_en != 0) && (pos == plen - 1);
            arm  = reg_wr && reg_addr == 4'd2 && m_cm == 1 && reg_wdata[0] == 1'b0;
            xfer = (m_pend != 0) && (m_en == 0 || last);
            if (m_en == 0 || last) pos = 0; else pos = pos + 1;
            if (xfer) begin
                l_div = n_div; l_per = n_per; l_wid = n_wid; m_pend = 0;
            end
            if (arm) begin
                n_div = s_div; n_per = s_per; n_wid = s_wid; m_pend = 1;
            end
            if (reg_wr) begin
                case (reg_addr)
                    4'd0: m_en = reg_wdata[0];
                    4'd2: m_cm = reg_wdata[0];
                    4'd4: s_div = reg_wdata[25:16];
                    4'd5: begin s_per = reg_wdata[11:0]; s_wid = reg_wdata[28:16]; end
                    default: ;
                endcase
            end
        end
    end

    // compare output with the model every cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (int'(pwm_out) != exp_out()) begin
                bad++;
                $display("FAIL %s: pwm_out=%0d expected %0d at %0t", cur_req, pwm_out, exp_out(), $time);
            end
        end
    end

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] e, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(a);
        #1;
        total++;
        if (reg_rdata !== e) begin
            bad++;
            $display("FAIL %s: read addr %0d got %h expected %h", req, a, reg_rdata, e);
        end
        reg_rd = 1'b0;
    endtask

    task automatic commit();
        wr_reg(2, 32'h1);
        wr_reg(2, 32'h0);
    endtask

    task automatic stage(input int dv, input int pr, input int wd);
        wr_reg(4, 32'(dv) << 16);
        wr_reg(5, (32'(wd) << 16) | 32'(pr));
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // direct measure of high time and period from output edges (R4, R5)
    task automatic measure(input int exp_hi, input int exp_per);
        int hi = 0, len = 0, g = 0;
        while (!(pwm_out == 1'b0) && g < 5000) begin @(negedge clk); g++; end
        while (pwm_out == 1'b0 && g < 5000) begin @(negedge clk); g++; end
        while (pwm_out == 1'b1 && g < 5000) begin @(negedge clk); hi++; len++; g++; end
        while (pwm_out == 1'b0 && g < 5000) begin @(negedge clk); len++; g++; end
        total++;
        if (hi != exp_hi) begin
            bad++; $display("FAIL R5: high cycles %0d expected %0d", hi, exp_hi);
        end
        total++;
        if (len != exp_per) begin
            bad++; $display("FAIL R4: period cycles %0d expected %0d", len, exp_per);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        run(3);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset values
        cur_req = "R1";
        rd_chk(0, 32'h0, "R1"); rd_chk(2, 32'h0, "R1");
        rd_chk(4, 32'h0, "R1"); rd_chk(5, 32'h0, "R1");
        // R2: field placement and masking
        cur_req = "R2";
        wr_reg(4, 32'hFFFF_FFFF); rd_chk(4, 32'h03FF_0000, "R2");
        wr_reg(5, 32'hFFFF_FFFF); rd_chk(5, 32'h1FFF_0FFF, "R2");
        wr_reg(0, 32'hFFFF_FFFE); rd_chk(0, 32'h0, "R2");
        wr_reg(2, 32'hFFFF_FFFF); rd_chk(2, 32'h1, "R2");
        wr_reg(2, 32'h0);          rd_chk(2, 32'h0, "R2");
        rd_chk(1, 32'h0, "R2"); rd_chk(7, 32'h0, "R2");
        @(negedge clk); reg_addr = 4'd5; #1; total++;
        if (reg_rdata !== 32'h0) begin
            bad++; $display("FAIL R2: idle read data %h expected 0", reg_rdata);
        end
        // clear running settings while disabled (R10)
        cur_req = "R10";
        stage(0, 0, 0); commit(); run(3);
        // R3: staged but uncommitted settings have no effect
        cur_req = "R3";
        stage(0, 3, 2); wr_reg(0, 32'h1); run(20);
        // R9: commit while running
        cur_req = "R9";
        commit(); run(20);
        cur_req = "R5";
        run(20);
        stage(2, 4, 3);
        cur_req = "R9";
        commit(); run(40);
        cur_req = "R4";
        measure(9, 15);
        // R6: zero width
        cur_req = "R6";
        stage(1, 3, 0); commit(); run(30);
        // R7: width at and beyond period+1
        cur_req = "R7";
        stage(1, 5, 6); commit(); run(40);
        stage(0, 2, 8191); commit(); run(20);
        // R5 with a different pattern
        cur_req = "R5";
        stage(3, 2, 1); commit(); run(40);
        measure(4, 12);
        // R8: disable forces low
        cur_req = "R8";
        wr_reg(0, 32'h0); run(10);
        // R10: commit while disabled
        cur_req = "R10";
        stage(0, 7, 3); commit(); run(5);
        // R8: restart from period start
        cur_req = "R8";
        wr_reg(0, 32'h1); run(40);
        wr_reg(0, 32'h0); run(3); wr_reg(0, 32'h1); run(30);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule